// File: doc/BRIEF.md
# Display Data Fetch Window Sequencer

This block sits beside the horizontal beam counter of a display controller. From the current slot number it decides on which slots of a scan line a bitplane memory fetch must be issued. It also reports the fetch window of the current line: where it starts, where it ends, how many memory fetches have been issued so far and how many bytes they carried.

The window settings are captured on the line-start strobe and stay fixed for the rest of that line. These settings are a start position, a stop position, a chipset-generation select, a fetch-width mode and a display resolution.

The start position is masked according to the generation. It does not have to be aligned to any fetch unit. The stop position does not end fetching. It only marks the point from which one more fetch block is completed. It is therefore clamped and then rounded up to the end of the fetch block that contains it. In wide modes the block is longer than the number of fetches it holds. Only one slot out of every two or four issues a fetch, and the rest stay idle.

Top module: `dffseq_top`

## Requirements
- R1: In the cycle after `line_start`, `first_slot` equals `start_pos` ANDed with 0xFC when `gen_sel`=0, or with 0xFE when `gen_sel`=1.
- R2: The stop position is masked with the same generation mask. If the result exceeds 0xD6, 0xD6 is used in its place.
- R3: In the cycle after `line_start`, `last_slot` is the clamped stop rounded up to a multiple of the fetch unit. The fetch unit is set by `width_mode` (0 = narrow, 1 or 2 = double, 3 = quad) and `res_sel` (0 = low, 1 = high, 2 or 3 = super-high). In narrow mode it is 8 slots. In double mode it is 16 for low resolution and 8 otherwise. In quad mode it is 32 for low, 16 for high and 8 for super-high.
- R4: `fetch_stb` is high combinationally on exactly those slots where all of the following hold: `hpos` ≥ `first_slot`, `hpos` < `last_slot`, `line_start` is low, and `hpos` is a multiple of the fetch divisor. The divisor is 2 for double-low, 4 for quad-low, 2 for quad-high and 1 otherwise.
- R5: `fetch_count` counts the `fetch_stb` slots since the last `line_start`. It reads zero in the cycle after `line_start`.
- R6: `byte_count` adds 2, 4 or 8 bytes for each fetch, for `width_mode` narrow, double or quad respectively. It is cleared together with `fetch_count`.
- R7: Changes to `start_pos`, `stop_pos`, `gen_sel`, `width_mode` or `res_sel` during a line have no effect until the next `line_start`.
- R8: If `hpos` never reaches the start slot before the next `line_start`, no `fetch_stb` occurs on that line and both counts stay zero.
- R9: A start position that is not aligned to the fetch unit or the divisor opens the window at the masked start slot. The first fetch falls on the first aligned slot at or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpos | input | 8 | Current horizontal slot number |
| line_start | input | 1 | Line-start strobe; captures settings, clears counts |
| start_pos | input | 8 | Fetch start position |
| stop_pos | input | 8 | Fetch stop (arm) position |
| gen_sel | input | 1 | 0 = oldest generation mask, 1 = later generations |
| width_mode | input | 2 | Fetch width mode |
| res_sel | input | 2 | Display resolution |
| fetch_stb | output | 1 | Fetch request on this slot |
| first_slot | output | 8 | First fetch slot of the line |
| last_slot | output | 8 | Slot at which the window closes |
| fetch_count | output | 9 | Fetches issued this line |
| byte_count | output | 12 | Bytes transferred this line |

## Verification
The hardest situation to reach from the ports is one where the captured line settings differ from those presently on the inputs. Only then does the bench show that the strobe follows the captured values and not the live ones. The bench reaches it by changing all five setting inputs in the middle of a slot sweep and checking the rest of that sweep against the original window. A second hard case is a line cut short before the start slot. A separate scenario issues `line_start` early and checks that the counts never moved.

// File: rtl/dffseq_pkg.sv
package dffseq_pkg;

    // Fetch width mode encodings
    localparam logic [1:0] WM_NARROW = 2'd0;
    localparam logic [1:0] WM_QUAD   = 2'd3;

    // Resolution encodings
    localparam logic [1:0] RES_LOW  = 2'd0;
    localparam logic [1:0] RES_HIGH = 2'd1;

    // Per-line fetch shape derived from the mode inputs
    typedef struct packed {
        logic [1:0] div_log2;   // log2 of slots per fetch
        logic [1:0] bpf_log2;   // log2 of bytes per fetch
    } fetch_shape_t;

endpackage

// File: rtl/dffseq_geom.sv
module dffseq_geom
    import dffseq_pkg::*;
#(
    parameter int HW        = 8,
    parameter int CLAMP_POS = 'hD6
) (
    input  logic [HW-1:0] start_pos,
    input  logic [HW-1:0] stop_pos,
    input  logic          gen_sel,
    input  logic [1:0]    width_mode,
    input  logic [1:0]    res_sel,
    output logic [HW-1:0] first_slot,
    output logic [HW-1:0] last_slot,
    output fetch_shape_t  shape
);
    localparam logic [HW-1:0] CLAMP = HW'(CLAMP_POS);

    logic [HW-1:0] mask;
    logic [HW-1:0] end_pos;
    logic [2:0]    unit_log2;
    logic [HW:0]   unit_m1;
    logic [HW:0]   rounded;

    always_comb begin
        mask = gen_sel ? {{(HW-1){1'b1}}, 1'b0} : {{(HW-2){1'b1}}, 2'b00};
        first_slot = start_pos & mask;
        end_pos = stop_pos & mask;
        if (end_pos > CLAMP) end_pos = CLAMP;

        unique case (width_mode)
            WM_NARROW: unit_log2 = 3'd3;
            WM_QUAD: begin
                if (res_sel == RES_LOW)       unit_log2 = 3'd5;
                else if (res_sel == RES_HIGH) unit_log2 = 3'd4;
                else                          unit_log2 = 3'd3;
            end
            default:   unit_log2 = (res_sel == RES_LOW) ? 3'd4 : 3'd3;
        endcase

        shape.div_log2 = 2'(unit_log2 - 3'd3);
        unique case (width_mode)
            WM_NARROW: shape.bpf_log2 = 2'd1;
            WM_QUAD:   shape.bpf_log2 = 2'd3;
            default:   shape.bpf_log2 = 2'd2;
        endcase

        unit_m1   = ((HW+1)'(1) << unit_log2) - (HW+1)'(1);
        rounded   = ({1'b0, end_pos} + unit_m1) & ~unit_m1;
        last_slot = rounded[HW-1:0];
    end
endmodule

// File: rtl/dffseq_gate.sv
module dffseq_gate
    import dffseq_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic [HW-1:0] hpos,
    input  logic          line_start,
    input  logic [HW-1:0] first_slot,
    input  logic [HW-1:0] last_slot,
    input  fetch_shape_t  shape,
    output logic          fetch_stb
);
    logic [HW-1:0] phase_mask;
    logic          in_window;
    logic          on_phase;

    always_comb begin
        phase_mask = (HW'(1) << shape.div_log2) - HW'(1);
        in_window  = (hpos >= first_slot) && (hpos < last_slot);
        on_phase   = (hpos & phase_mask) == '0;
        fetch_stb  = in_window && on_phase && !line_start;
    end
endmodule

// File: rtl/dffseq_top.sv
module dffseq_top
    import dffseq_pkg::*;
#(
    parameter int HW        = 8,
    parameter int CLAMP_POS = 'hD6,
    localparam int FCW      = HW + 1,
    localparam int BCW      = HW + 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HW-1:0]  hpos,
    input  logic           line_start,
    input  logic [HW-1:0]  start_pos,
    input  logic [HW-1:0]  stop_pos,
    input  logic           gen_sel,
    input  logic [1:0]     width_mode,
    input  logic [1:0]     res_sel,
    output logic           fetch_stb,
    output logic [HW-1:0]  first_slot,
    output logic [HW-1:0]  last_slot,
    output logic [FCW-1:0] fetch_count,
    output logic [BCW-1:0] byte_count
);
    typedef struct packed {
        logic [HW-1:0]  first;
        logic [HW-1:0]  last;
        fetch_shape_t   shape;
        logic [FCW-1:0] fcnt;
        logic [BCW-1:0] bcnt;
    } state_t;

    state_t        st_d, st_q;
    logic [HW-1:0] geom_first;
    logic [HW-1:0] geom_last;
    fetch_shape_t  geom_shape;
    logic          stb;

    dffseq_geom #(.HW(HW), .CLAMP_POS(CLAMP_POS)) u_geom (
        .start_pos  (start_pos),
        .stop_pos   (stop_pos),
        .gen_sel    (gen_sel),
        .width_mode (width_mode),
        .res_sel    (res_sel),
        .first_slot (geom_first),
        .last_slot  (geom_last),
        .shape      (geom_shape)
    );

    dffseq_gate #(.HW(HW)) u_gate (
        .hpos       (hpos),
        .line_start (line_start),
        .first_slot (st_q.first),
        .last_slot  (st_q.last),
        .shape      (st_q.shape),
        .fetch_stb  (stb)
    );

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d.first = geom_first;
            st_d.last  = geom_last;
            st_d.shape = geom_shape;
            st_d.fcnt  = '0;
            st_d.bcnt  = '0;
        end else if (stb) begin
            st_d.fcnt = st_q.fcnt + FCW'(1);
            st_d.bcnt = st_q.bcnt + (BCW'(1) << st_q.shape.bpf_log2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_stb   = stb;
    assign first_slot  = st_q.first;
    assign last_slot   = st_q.last;
    assign fetch_count = st_q.fcnt;
    assign byte_count  = st_q.bcnt;
endmodule

// File: rtl/dffseq_chk.sv
module dffseq_chk #(
    parameter int HW  = 8,
    parameter int FCW = HW + 1,
    parameter int BCW = HW + 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [HW-1:0]  hpos,
    input logic           line_start,
    input logic [HW-1:0]  start_pos,
    input logic           gen_sel,
    input logic           fetch_stb,
    input logic [HW-1:0]  first_slot,
    input logic [HW-1:0]  last_slot,
    input logic [FCW-1:0] fetch_count,
    input logic [BCW-1:0] byte_count
);
    a_r1_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> first_slot ==
            ($past(start_pos) & ($past(gen_sel) ? {{(HW-1){1'b1}}, 1'b0}
                                                : {{(HW-2){1'b1}}, 2'b00})));

    a_r3_last_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot[2:0] == 3'b000);

    a_r2_last_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot <= HW'('hE0));

    a_r4_stb_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> (!line_start && hpos >= first_slot && hpos < last_slot));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !line_start) |=> fetch_count == $past(fetch_count) + FCW'(1));

    a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stb && !line_start) |=> ($stable(fetch_count) && $stable(byte_count)));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (fetch_count == '0 && byte_count == '0));

    a_r6_bytes_grow: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> byte_count > $past(byte_count));
endmodule

bind dffseq_top dffseq_chk #(.HW(HW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hpos        (hpos),
    .line_start  (line_start),
    .start_pos   (start_pos),
    .gen_sel     (gen_sel),
    .fetch_stb   (fetch_stb),
    .first_slot  (first_slot),
    .last_slot   (last_slot),
    .fetch_count (fetch_count),
    .byte_count  (byte_count)
);

// File: tb/dffseq_top_tb.sv
module dffseq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hpos = '0;
    logic        line_start = 1'b0;
    logic [7:0]  start_pos = '0;
    logic [7:0]  stop_pos = '0;
    logic        gen_sel = 1'b0;
    logic [1:0]  width_mode = '0;
    logic [1:0]  res_sel = '0;
    logic        fetch_stb;
    logic [7:0]  first_slot, last_slot;
    logic [8:0]  fetch_count;
    logic [11:0] byte_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dffseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_start(line_start),
        .start_pos(start_pos), .stop_pos(stop_pos), .gen_sel(gen_sel),
        .width_mode(width_mode), .res_sel(res_sel), .fetch_stb(fetch_stb),
        .first_slot(first_slot), .last_slot(last_slot),
        .fetch_count(fetch_count), .byte_count(byte_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Model of the requirements: returns first, last, divisor, bytes per fetch
    task automatic model(input int s, input int p, input bit g, input int wm, input int rs,
                         output int f, output int l, output int dv, output int bpf);
        int m, e, unit;
        m = g ? 'hFE : 'hFC;
        f = s & m;
        e = p & m;
        if (e > 'hD6) e = 'hD6;                       // R2
        if (wm == 0) unit = 8;
        else if (wm == 3) unit = (rs == 0) ? 32 : (rs == 1) ? 16 : 8;
        else unit = (rs == 0) ? 16 : 8;
        l = (e + unit - 1) & ~(unit - 1);             // R3
        dv = unit / 8;
        bpf = (wm == 0) ? 2 : (wm == 3) ? 8 : 4;
    endtask

    // One line: capture settings, sweep hpos 1..max_h, optionally disturb mid-line
    task automatic run_line(input string name, input int s, input int p, input bit g,
                            input int wm, input int rs, input int max_h, input bit disturb);
        int f, l, dv, bpf, nexp, bad;
        model(s, p, g, wm, rs, f, l, dv, bpf);
        @(negedge clk);
        start_pos = 8'(s); stop_pos = 8'(p); gen_sel = g;
        width_mode = 2'(wm); res_sel = 2'(rs);
        hpos = 8'd0; line_start = 1'b1;
        #1;
        check(fetch_stb == 1'b0, {name, " R4 no strobe on line_start"}, fetch_stb, 0);
        @(negedge clk);
        line_start = 1'b0;
        check(first_slot == 8'(f), {name, " R1 first_slot"}, first_slot, f);
        check(last_slot == 8'(l), {name, " R3 last_slot"}, last_slot, l);
        check(fetch_count == 0 && byte_count == 0, {name, " R5 cleared"}, fetch_count, 0);
        nexp = 0; bad = 0;
        for (int h = 1; h <= max_h; h++) begin
            hpos = 8'(h);
            if (disturb && h == 'h20) begin
                start_pos = 8'h02; stop_pos = 8'hF0; gen_sel = ~g;
                width_mode = 2'(3 - wm); res_sel = 2'(2 - rs);
            end
            #1;
            begin
                bit e = (h >= f) && (h < l) && (h % dv == 0);
                if (e) nexp++;
                if (fetch_stb != e && bad == 0) begin
                    bad = 1;
                    check(0, $sformatf("%s R4 strobe at hpos %0d", name, h), fetch_stb, e);
                end
            end
            @(negedge clk);
        end
        if (bad == 0) check(1, {name, " R4"}, 0, 0);
        check(fetch_count == 9'(nexp), {name, " R5 fetch_count"}, fetch_count, nexp);
        check(byte_count == 12'(nexp * bpf), {name, " R6 byte_count"}, byte_count, nexp * bpf);
    endtask

    task automatic t_reset();
        #1;
        check(fetch_stb == 0, "reset R4 strobe", fetch_stb, 0);
        check(first_slot == 0 && last_slot == 0, "reset R1 slots", last_slot, 0);
        check(fetch_count == 0 && byte_count == 0, "reset R5 counts", fetch_count, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_line("narrow_later",  'h38, 'hD0, 1, 0, 0, 255, 0);  // R1 R3 R4
        run_line("narrow_oldest", 'h3A, 'hD1, 0, 0, 1, 255, 0);  // R1 gen mask
        run_line("clamp_stop",    'h40, 'hF0, 1, 0, 2, 255, 0);  // R2
        run_line("double_low_r9", 'h39, 'hA0, 1, 1, 0, 255, 0);  // R9 unaligned
        run_line("double_high",   'h30, 'hC2, 1, 2, 1, 255, 0);
        run_line("quad_low",      'h3B, 'hC4, 1, 3, 0, 255, 0);  // R9 quad
        run_line("quad_high",     'h36, 'hB8, 1, 3, 1, 255, 0);
        run_line("quad_super",    'h20, 'hE8, 0, 3, 2, 255, 0);  // R2 clamp
        run_line("r7_midline",    'h48, 'h90, 1, 1, 0, 255, 1);  // R7
        run_line("r8_short_line", 'h60, 'hC0, 1, 0, 0, 'h50, 0); // R8
        run_line("after_short",   'h24, 'h60, 0, 2, 2, 255, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule